// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in first-out buffer out of a ring of identical small storage slices, without any shared memory or glue logic between them. Two ownership tokens circulate around the ring: a write token, held by the only slice allowed to accept incoming words, and a read token, held by the only slice allowed to deliver outgoing words. A slice fills all of its locations during one visit of the write token. It then hands the token to the next slice with a one-cycle pass pulse. The read token follows the same path behind it, so words leave in exactly the order they arrived.

Each slice carries a strap input that marks it as the ring leader. At reset the leader takes both tokens and every other slice holds none. The wrapper instantiates a parameterised number of slices. Each slice's pass outputs feed the next slice's pass inputs, and the last slice closes the ring back to the first. The whole ring runs from one clock: the write and read clocks are tied together.

Top module: `token_ring_fifo`

## Requirements
- R1: While reset is high and on the first cycle after it, `empty` is 1, `full` is 0, `rd_valid` is 0, and both `wr_slot` and `rd_slot` equal one-hot 1, meaning slice 0, the strapped leader, holds both tokens.
- R2: Every word delivered on `rd_data` equals the oldest accepted word not yet delivered, across every token handoff.
- R3: Exactly one bit of `wr_slot` is set at all times. The write token moves from slice i to slice i+1 at the clock edge that accepts the DEPTH-th write of its visit, and it never moves without an accepted write.
- R4: Exactly one bit of `rd_slot` is set at all times. The read token moves from slice i to slice i+1 at the clock edge that accepts the DEPTH-th read of its visit.
- R5: `full` is 1 exactly when SLICES*DEPTH words are stored. A write request (`wr_en_n` low) while `full` is 1 is dropped and never appears at the output.
- R6: `empty` is 1 exactly when no word is stored. A read request (`rd_en_n` low) while `empty` is 1 leaves `rd_valid` at 0 on the next cycle.
- R7: A read accepted at a clock edge (`rd_en_n` low and `empty` 0) presents its word on `rd_data` with `rd_valid` 1 during the following cycle only.
- R8: A write and a read requested in the same cycle are both accepted when the buffer is neither full nor empty, and the stored count stays unchanged.
- R9: After the last slice (index SLICES-1) passes a token, that token returns to slice 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for writes, reads and token passing |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free location remains in the ring |
| rd_en_n | input | 1 | Active-low read request |
| rd_data | output | DATA_W | Delivered word, valid when rd_valid is 1 |
| rd_valid | output | 1 | rd_data holds a word read at the previous edge |
| empty | output | 1 | No stored word remains in the ring |
| wr_slot | output | SLICES | One-hot index of the slice holding the write token |
| rd_slot | output | SLICES | One-hot index of the slice holding the read token |

## Verification
A write-token pass and a read-token pass can land on the same clock edge. So can a write and a read into one slice while that slice also holds both tokens. The bench provokes both cases by streaming concurrent writes and reads starting from empty, from part-filled states and from full. In those states the two pointers cross slice boundaries on the same or adjacent cycles. Every cycle, a reference queue in the bench predicts the token positions, both flags and the delivered word, and the outputs are compared against it.

// File: rtl/cascade_pkg.sv
package cascade_pkg;

  // Index of the slice upstream of slice i in a ring of n slices.
  function automatic int ring_prev(input int i, input int n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

  // Strap value for slice i: low marks the ring leader.
  function automatic logic leader_strap(input int i);
    return (i == 0) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/slice_store.sv
module slice_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port array with registered read: maps to block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end

endmodule

// File: rtl/slice_token.sv
module slice_token #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_n,
  input  logic             step,
  input  logic             pass_in,
  output logic             own,
  output logic             pass_out,
  output logic [PTR_W-1:0] ptr
);

  // Handoff pulse lasts the cycle in which the final location of the visit is used.
  assign pass_out = step && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      own <= ~strap_n;
      ptr <= '0;
    end else begin
      if (pass_in)       own <= 1'b1;
      else if (pass_out) own <= 1'b0;
      if (step) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/chain_slice.sv
module chain_slice #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  input  logic              wr_pass_in,
  input  logic              rd_pass_in,
  output logic              wr_pass_out,
  output logic              rd_pass_out,
  output logic              wr_own,
  output logic              rd_own,
  output logic              slice_full,
  output logic              slice_empty,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] wptr, rptr;
  logic             wr_go, rd_go;

  assign slice_full  = (count == CNT_W'(DEPTH));
  assign slice_empty = (count == '0);
  assign wr_go = wr_own && !wr_en_n && !slice_full;
  assign rd_go = rd_own && !rd_en_n && !slice_empty;

  slice_token #(.DEPTH(DEPTH)) u_wtok (
    .clk(clk), .rst(rst), .strap_n(strap_n), .step(wr_go),
    .pass_in(wr_pass_in), .own(wr_own), .pass_out(wr_pass_out), .ptr(wptr)
  );

  slice_token #(.DEPTH(DEPTH)) u_rtok (
    .clk(clk), .rst(rst), .strap_n(strap_n), .step(rd_go),
    .pass_in(rd_pass_in), .own(rd_own), .pass_out(rd_pass_out), .ptr(rptr)
  );

  slice_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(wr_go), .waddr(wptr), .wdata(wr_data),
    .re(rd_go), .raddr(rptr), .rdata(rd_data), .rvalid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (wr_go && !rd_go) count <= count + 1'b1;
    else if (rd_go && !wr_go) count <= count - 1'b1;
  end

endmodule

// File: rtl/token_ring_fifo.sv
module token_ring_fifo
  import cascade_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 8,
  parameter int SLICES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic [SLICES-1:0] wr_slot,
  output logic [SLICES-1:0] rd_slot
);

  logic [SLICES-1:0] wpass, rpass, s_full, s_empty, s_valid;
  logic [DATA_W-1:0] s_data [SLICES];

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int UP = ring_prev(i, SLICES);
    chain_slice #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_slice (
      .clk(clk), .rst(rst), .strap_n(leader_strap(i)),
      .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
      .wr_pass_in(wpass[UP]), .rd_pass_in(rpass[UP]),
      .wr_pass_out(wpass[i]), .rd_pass_out(rpass[i]),
      .wr_own(wr_slot[i]), .rd_own(rd_slot[i]),
      .slice_full(s_full[i]), .slice_empty(s_empty[i]),
      .rd_data(s_data[i]), .rd_valid(s_valid[i])
    );
  end

  assign full     = |(wr_slot & s_full);
  assign empty    = |(rd_slot & s_empty);
  assign rd_valid = |s_valid;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < SLICES; i++)
      rd_data = rd_data | (s_data[i] & {DATA_W{s_valid[i]}});
  end

endmodule

// File: rtl/token_ring_fifo_chk.sv
module token_ring_fifo_chk #(
  parameter int SLICES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic              full,
  input logic              empty,
  input logic              rd_valid,
  input logic [SLICES-1:0] wr_slot,
  input logic [SLICES-1:0] rd_slot
);

  AST_WR_TOKEN_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_slot) == 1); // R3
  AST_RD_TOKEN_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_slot) == 1); // R4
  AST_WR_TOKEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    wr_en_n |=> $stable(wr_slot)); // R3
  AST_RD_TOKEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    rd_en_n |=> $stable(rd_slot)); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && rd_en_n) |=> full); // R5
  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (empty && !rd_en_n) |=> !rd_valid); // R6
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (!empty && !rd_en_n) |=> rd_valid); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R5

endmodule

bind token_ring_fifo token_ring_fifo_chk #(.SLICES(SLICES)) u_chk (
  .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
  .full(full), .empty(empty), .rd_valid(rd_valid),
  .wr_slot(wr_slot), .rd_slot(rd_slot)
);

// File: tb/token_ring_fifo_bench.sv
module token_ring_fifo_bench;
  localparam int DATA_W = 9;
  localparam int DEPTH  = 8;
  localparam int SLICES = 3;
  localparam int CAP    = DEPTH * SLICES;

  typedef struct packed {
    logic [7:0] cyc;
    logic       wr;
    logic       rd;
  } phase_t;

  localparam phase_t PLAN [0:9] = '{
    '{8'd26, 1'b1, 1'b0},   // fill past capacity (R5)
    '{8'd3,  1'b1, 1'b1},   // both while full
    '{8'd30, 1'b0, 1'b1},   // drain past empty (R6)
    '{8'd40, 1'b1, 1'b1},   // streaming from empty (R8)
    '{8'd5,  1'b0, 1'b1},
    '{8'd9,  1'b1, 1'b0},
    '{8'd4,  1'b0, 1'b1},
    '{8'd20, 1'b1, 1'b1},
    '{8'd13, 1'b1, 1'b0},
    '{8'd30, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [DATA_W-1:0] wr_data = '0;
  logic full, empty, rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [SLICES-1:0] wr_slot, rd_slot;

  int n_chk = 0, n_fail = 0;
  int q [512];
  int head = 0, tail = 0, cnt = 0, seq = 1;
  int wr_total = 0, rd_total = 0;
  int prev_exp = 0;
  bit prev_acc = 0, prev_both = 0, done = 0;

  always #5 clk = ~clk;

  token_ring_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SLICES(SLICES)) u_token_ring_fifo (
    .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .wr_data(wr_data), .full(full),
    .rd_en_n(rd_en_n), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
    .wr_slot(wr_slot), .rd_slot(rd_slot)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    head = 0; tail = 0; cnt = 0; wr_total = 0; rd_total = 0;
    prev_acc = 0; prev_both = 0;
  endtask

  task automatic check_reset_state();
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 wr_slot", int'(wr_slot), 1);
    check("R1 rd_slot", int'(rd_slot), 1);
  endtask

  // Called at a falling edge: check outputs, then drive the next cycle.
  task automatic cycle(input bit w, input bit r);
    int wi, ri;
    bit wa, ra;
    check(prev_both ? "R8 rd_valid" : "R7 rd_valid", int'(rd_valid), int'(prev_acc));
    if (prev_acc) check("R2 rd_data", int'(rd_data), prev_exp);
    check("R5 full", int'(full), int'(cnt == CAP));
    check("R6 empty", int'(empty), int'(cnt == 0));
    wi = (wr_total / DEPTH) % SLICES;
    ri = (rd_total / DEPTH) % SLICES;
    check((wi == 0 && wr_total > 0) ? "R9 wr_slot" : "R3 wr_slot", int'(wr_slot), 1 << wi);
    check((ri == 0 && rd_total > 0) ? "R9 rd_slot" : "R4 rd_slot", int'(rd_slot), 1 << ri);
    wa = w && (cnt < CAP);
    ra = r && (cnt > 0);
    wr_data = DATA_W'(seq);
    if (ra) begin prev_exp = q[head % 512]; head++; rd_total++; end
    if (wa) begin q[tail % 512] = seq % (1 << DATA_W); tail++; wr_total++; seq++; end
    cnt = cnt + int'(wa) - int'(ra);
    prev_acc = ra;
    prev_both = wa && ra;
    wr_en_n = !w;
    rd_en_n = !r;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    check_reset_state();
    for (int p = 0; p < 10; p++)
      for (int c = 0; c < int'(PLAN[p].cyc); c++)
        cycle(PLAN[p].wr, PLAN[p].rd);
    // Directed: reset in the middle of traffic returns tokens to the leader.
    for (int c = 0; c < 11; c++) cycle(1'b1, 1'b0);
    wr_en_n = 1'b1; rd_en_n = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    model_reset();
    @(posedge clk); @(negedge clk);
    check_reset_state();
    // Directed: one-slice boundary exactly, then read back across it.
    for (int c = 0; c < DEPTH + 1; c++) cycle(1'b1, 1'b0);
    for (int c = 0; c < DEPTH + 2; c++) cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule